// File: doc/BRIEF.md
# Dual-Calendar Channel Flow-Control Engine

This block exchanges per-channel backpressure between two chips. The sending half scans a programmable calendar. Each slot of the calendar names a logical channel. For every slot the block emits that channel's buffer-room indicator as one status bit, where 1 means XON and 0 means XOFF. The bits are packed into 16-bit chunks, and one chunk is emitted for each outgoing control word. Every chunk also carries a link-level status bit, a start-of-calendar flag, the calendar-select bit and a 4-bit CRC.

The receiving half checks each incoming chunk. Using the calendar named by the select bit, it scatters the status bits into a staging vector. When a complete, error-free pass has arrived, it commits that vector as the per-channel transmit permits.

Two calendars are held, each with its own length and slot-to-channel map. The select bit changes only between passes. Software can therefore rewrite the idle calendar and then move traffic onto it without disturbing the channels that are in use.

Top module: `fc_flow_cal`

## Requirements
- R1: Bit j of chunk k carries the fill indicator of the channel mapped to slot 16k+j of the selected calendar (1 = XON). Bits for slots at or beyond the calendar length are 0.
- R2: `fc_sof_o` is 1 exactly on chunk 0 of a pass. `fc_link_o` follows `link_ok_i`. `fc_req_i` advances to the next chunk and wraps after the last chunk, which is chunk (length-1)/16.
- R3: `fc_crc_o` is a CRC-4 over the 19-bit message {sof, sel, link, data[15:0]}, taken MSB first. The polynomial is x^4+x+1 (feedback mask 4'b0011), the register starts at 4'b1111, and there is no final inversion.
- R4: `permit_o` changes only on the clock after the last chunk of a pass is accepted. Earlier chunks of a multi-chunk pass leave it unchanged.
- R5: A chunk whose CRC does not match is discarded, along with the whole pass it belongs to. The previous permits are held.
- R6: If any chunk of a pass carries link status 0, the commit sets every permit to 0, whatever the channel bits are.
- R7: The sending half loads `cfg_sel_i` only when it wraps to chunk 0. A change of `fc_sel_o` therefore appears only together with `fc_sof_o`.
- R8: The receiving half latches the select bit from the start chunk. A later chunk in the same pass with a different select bit aborts the pass. A chunk without the start flag, arriving while no pass is open, is ignored.
- R9: A write port sets the slot-to-channel entry (`cfg_we_i`) and the length (`cfg_len_we_i`, range 1..MAX_SLOTS) of the calendar chosen by `cfg_cal_i`. After reset, both calendars have length NUM_CH and map slot s to channel s mod NUM_CH.
- R10: After reset, all permits are 0, and the sending half is on chunk 0 with calendar 0.
- R11: When several slots in a pass name the same channel, the highest-numbered slot decides that channel's permit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Write a slot map entry |
| cfg_len_we_i | input | 1 | Write a calendar length |
| cfg_cal_i | input | 1 | Calendar being written |
| cfg_slot_i | input | SLOT_W | Slot index |
| cfg_ch_i | input | CH_W | Channel for the slot |
| cfg_len_i | input | LEN_W | Calendar length |
| cfg_sel_i | input | 1 | Calendar requested for outgoing status |
| fill_ok_i | input | NUM_CH | Local buffer room per channel (1 = XON) |
| link_ok_i | input | 1 | Local link-level status |
| fc_req_i | input | 1 | Control word leaving; advance chunk |
| fc_data_o | output | CHUNK_W | Outgoing status chunk |
| fc_sof_o | output | 1 | Outgoing chunk is slot-0 chunk |
| fc_sel_o | output | 1 | Outgoing calendar select |
| fc_link_o | output | 1 | Outgoing link status |
| fc_crc_o | output | 4 | Outgoing CRC-4 |
| rx_valid_i | input | 1 | Incoming chunk valid |
| rx_data_i | input | CHUNK_W | Incoming status chunk |
| rx_sof_i | input | 1 | Incoming start-of-calendar flag |
| rx_sel_i | input | 1 | Incoming calendar select |
| rx_link_i | input | 1 | Incoming link status |
| rx_crc_i | input | 4 | Incoming CRC-4 |
| permit_o | output | NUM_CH | Per-channel transmit permit |

## Verification
A corrupted staging vector or chunk counter stays hidden until the next commit. It then shows on `permit_o` one clock after the final chunk of a pass, so each check sends a full pass and samples the permits right after it. A wrong select or chunk index in the sending half shows immediately, on the same cycle, in `fc_data_o`, `fc_sof_o` and `fc_crc_o`. Multi-chunk passes, a select change in mid-pass and duplicate channel slots are the cases that separate correct bookkeeping from merely plausible output.

// File: rtl/fc_cal_pkg.sv
package fc_cal_pkg;
  localparam int CRC_W = 4;
  localparam logic [CRC_W-1:0] CRC_POLY = 4'h3;
  localparam logic [CRC_W-1:0] CRC_INIT = 4'hF;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = c[CRC_W-1] ^ b;
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction
endpackage

// File: rtl/fc_crc4.sv
module fc_crc4 import fc_cal_pkg::*; #(
  parameter int W = 19
) (
  input  logic [W-1:0]     msg_i,
  output logic [CRC_W-1:0] crc_o
);
  always_comb begin
    crc_o = CRC_INIT;
    for (int i = W - 1; i >= 0; i--) crc_o = crc_step(crc_o, msg_i[i]);
  end
endmodule

// File: rtl/fc_cal_table.sv
module fc_cal_table #(
  parameter int NUM_CH    = 8,
  parameter int MAX_SLOTS = 32,
  parameter int CH_W      = 3,
  parameter int SLOT_W    = 5,
  parameter int LEN_W     = 6
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic                                  we_i,
  input  logic                                  len_we_i,
  input  logic                                  cal_i,
  input  logic [SLOT_W-1:0]                     slot_i,
  input  logic [CH_W-1:0]                       ch_i,
  input  logic [LEN_W-1:0]                      len_i,
  output logic [1:0][MAX_SLOTS-1:0][CH_W-1:0]   map_o,
  output logic [1:0][LEN_W-1:0]                 len_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        len_o[c] <= LEN_W'(NUM_CH);
        for (int s = 0; s < MAX_SLOTS; s++) map_o[c][s] <= CH_W'(s % NUM_CH);
      end
    end else begin
      if (we_i && (int'(slot_i) < MAX_SLOTS) && (int'(ch_i) < NUM_CH))
        map_o[cal_i][slot_i] <= ch_i;
      if (len_we_i && (len_i != '0) && (int'(len_i) <= MAX_SLOTS))
        len_o[cal_i] <= len_i;
    end
  end
endmodule

// File: rtl/fc_cal_gen.sv
module fc_cal_gen import fc_cal_pkg::*; #(
  parameter int NUM_CH    = 8,
  parameter int MAX_SLOTS = 32,
  parameter int CHUNK_W   = 16,
  parameter int CH_W      = 3,
  parameter int SLOT_W    = 5,
  parameter int LEN_W     = 6,
  parameter int CIDX_W    = 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [1:0][MAX_SLOTS-1:0][CH_W-1:0] map_i,
  input  logic [1:0][LEN_W-1:0]               len_i,
  input  logic [NUM_CH-1:0]                   fill_ok_i,
  input  logic                                link_ok_i,
  input  logic                                req_i,
  input  logic                                sel_req_i,
  output logic [CHUNK_W-1:0]                  data_o,
  output logic                                sof_o,
  output logic                                sel_o,
  output logic                                link_o,
  output logic [CRC_W-1:0]                    crc_o
);
  logic [CIDX_W-1:0] idx_q;
  logic              sel_q;
  int                last_idx;
  logic              wrap;

  always_comb begin
    last_idx = (int'(len_i[sel_q]) - 1) / CHUNK_W;
    wrap     = int'(idx_q) >= last_idx;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      sel_q <= 1'b0;
    end else if (req_i) begin
      if (wrap) begin
        idx_q <= '0;
        sel_q <= sel_req_i;   // calendar switch only at pass boundary
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  always_comb begin
    data_o = '0;
    for (int j = 0; j < CHUNK_W; j++) begin
      int s;
      s = int'(idx_q) * CHUNK_W + j;
      if (s < int'(len_i[sel_q])) data_o[j] = fill_ok_i[map_i[sel_q][SLOT_W'(s)]];
    end
  end

  assign sof_o  = (idx_q == '0);
  assign sel_o  = sel_q;
  assign link_o = link_ok_i;

  fc_crc4 #(.W(CHUNK_W + 3)) u_crc (
    .msg_i ({sof_o, sel_o, link_o, data_o}),
    .crc_o (crc_o)
  );
endmodule

// File: rtl/fc_cal_rx.sv
module fc_cal_rx import fc_cal_pkg::*; #(
  parameter int NUM_CH    = 8,
  parameter int MAX_SLOTS = 32,
  parameter int CHUNK_W   = 16,
  parameter int CH_W      = 3,
  parameter int SLOT_W    = 5,
  parameter int LEN_W     = 6,
  parameter int CIDX_W    = 1
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [1:0][MAX_SLOTS-1:0][CH_W-1:0] map_i,
  input  logic [1:0][LEN_W-1:0]               len_i,
  input  logic                                valid_i,
  input  logic [CHUNK_W-1:0]                  data_i,
  input  logic                                sof_i,
  input  logic                                sel_i,
  input  logic                                link_i,
  input  logic [CRC_W-1:0]                    crc_i,
  output logic [NUM_CH-1:0]                   permit_o
);
  logic [CRC_W-1:0]  crc_calc;
  logic              busy_q, sel_q, link_q;
  logic [CIDX_W-1:0] idx_q;
  logic [NUM_CH-1:0] stage_q, stage_nx;
  logic              use_sel, lnk_nx, accept, is_last;
  logic [CIDX_W-1:0] cidx;

  fc_crc4 #(.W(CHUNK_W + 3)) u_crc (
    .msg_i ({sof_i, sel_i, link_i, data_i}),
    .crc_o (crc_calc)
  );

  always_comb begin
    use_sel  = sof_i ? sel_i : sel_q;
    cidx     = sof_i ? '0 : idx_q;
    lnk_nx   = sof_i ? link_i : (link_q & link_i);
    stage_nx = sof_i ? '0 : stage_q;
    for (int j = 0; j < CHUNK_W; j++) begin
      int s;
      s = int'(cidx) * CHUNK_W + j;
      // ascending scan: highest slot naming a channel wins
      if (s < int'(len_i[use_sel])) stage_nx[map_i[use_sel][SLOT_W'(s)]] = data_i[j];
    end
    is_last = int'(cidx) >= (int'(len_i[use_sel]) - 1) / CHUNK_W;
    accept  = valid_i && (crc_calc == crc_i) && (sof_i || (busy_q && (sel_i == sel_q)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      sel_q    <= 1'b0;
      link_q   <= 1'b0;
      idx_q    <= '0;
      stage_q  <= '0;
      permit_o <= '0;
    end else if (valid_i) begin
      if (accept) begin
        stage_q <= stage_nx;
        sel_q   <= use_sel;
        link_q  <= lnk_nx;
        if (is_last) begin
          busy_q   <= 1'b0;
          permit_o <= lnk_nx ? stage_nx : '0;
        end else begin
          busy_q <= 1'b1;
          idx_q  <= cidx + 1'b1;
        end
      end else begin
        busy_q <= 1'b0;   // drop open pass on error or select mismatch
      end
    end
  end
endmodule

// File: rtl/fc_flow_cal.sv
module fc_flow_cal import fc_cal_pkg::*; #(
  parameter  int NUM_CH    = 8,
  parameter  int MAX_SLOTS = 32,
  parameter  int CHUNK_W   = 16,
  localparam int CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int SLOT_W    = (MAX_SLOTS > 1) ? $clog2(MAX_SLOTS) : 1,
  localparam int LEN_W     = $clog2(MAX_SLOTS + 1),
  localparam int NCHUNK    = (MAX_SLOTS + CHUNK_W - 1) / CHUNK_W,
  localparam int CIDX_W    = (NCHUNK > 1) ? $clog2(NCHUNK) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic               cfg_len_we_i,
  input  logic               cfg_cal_i,
  input  logic [SLOT_W-1:0]  cfg_slot_i,
  input  logic [CH_W-1:0]    cfg_ch_i,
  input  logic [LEN_W-1:0]   cfg_len_i,
  input  logic               cfg_sel_i,
  input  logic [NUM_CH-1:0]  fill_ok_i,
  input  logic               link_ok_i,
  input  logic               fc_req_i,
  output logic [CHUNK_W-1:0] fc_data_o,
  output logic               fc_sof_o,
  output logic               fc_sel_o,
  output logic               fc_link_o,
  output logic [CRC_W-1:0]   fc_crc_o,
  input  logic               rx_valid_i,
  input  logic [CHUNK_W-1:0] rx_data_i,
  input  logic               rx_sof_i,
  input  logic               rx_sel_i,
  input  logic               rx_link_i,
  input  logic [CRC_W-1:0]   rx_crc_i,
  output logic [NUM_CH-1:0]  permit_o
);
  logic [1:0][MAX_SLOTS-1:0][CH_W-1:0] map;
  logic [1:0][LEN_W-1:0]               len;

  fc_cal_table #(.NUM_CH(NUM_CH), .MAX_SLOTS(MAX_SLOTS), .CH_W(CH_W),
                 .SLOT_W(SLOT_W), .LEN_W(LEN_W)) u_table (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .len_we_i(cfg_len_we_i), .cal_i(cfg_cal_i),
    .slot_i(cfg_slot_i), .ch_i(cfg_ch_i), .len_i(cfg_len_i),
    .map_o(map), .len_o(len)
  );

  fc_cal_gen #(.NUM_CH(NUM_CH), .MAX_SLOTS(MAX_SLOTS), .CHUNK_W(CHUNK_W), .CH_W(CH_W),
               .SLOT_W(SLOT_W), .LEN_W(LEN_W), .CIDX_W(CIDX_W)) u_gen (
    .clk_i, .rst_ni, .map_i(map), .len_i(len),
    .fill_ok_i, .link_ok_i, .req_i(fc_req_i), .sel_req_i(cfg_sel_i),
    .data_o(fc_data_o), .sof_o(fc_sof_o), .sel_o(fc_sel_o),
    .link_o(fc_link_o), .crc_o(fc_crc_o)
  );

  fc_cal_rx #(.NUM_CH(NUM_CH), .MAX_SLOTS(MAX_SLOTS), .CHUNK_W(CHUNK_W), .CH_W(CH_W),
              .SLOT_W(SLOT_W), .LEN_W(LEN_W), .CIDX_W(CIDX_W)) u_rx (
    .clk_i, .rst_ni, .map_i(map), .len_i(len),
    .valid_i(rx_valid_i), .data_i(rx_data_i), .sof_i(rx_sof_i), .sel_i(rx_sel_i),
    .link_i(rx_link_i), .crc_i(rx_crc_i), .permit_o
  );
endmodule

// File: rtl/fc_cal_chk.sv
module fc_cal_chk import fc_cal_pkg::*; #(
  parameter int NUM_CH  = 8,
  parameter int CHUNK_W = 16
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               rx_valid_i,
  input logic [CHUNK_W-1:0] rx_data_i,
  input logic               rx_sof_i,
  input logic               rx_sel_i,
  input logic               rx_link_i,
  input logic [CRC_W-1:0]   rx_crc_i,
  input logic [NUM_CH-1:0]  permit_o,
  input logic               fc_sel_o,
  input logic               fc_sof_o,
  input logic               fc_req_i
);
  logic [CRC_W-1:0] exp_crc;

  fc_crc4 #(.W(CHUNK_W + 3)) u_ref_crc (
    .msg_i ({rx_sof_i, rx_sel_i, rx_link_i, rx_data_i}),
    .crc_o (exp_crc)
  );

  // R4
  permit_after_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(permit_o) |-> $past(rx_valid_i));

  // R5
  crc_bad_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && (exp_crc != rx_crc_i)) |=> $stable(permit_o));

  // R6
  link_off_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(permit_o) && (permit_o != '0)) |-> $past(rx_link_i));

  // R7
  sel_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fc_sel_o) |-> (fc_sof_o && $past(fc_req_i)));
endmodule

bind fc_flow_cal fc_cal_chk #(.NUM_CH(NUM_CH), .CHUNK_W(CHUNK_W)) u_chk (
  .clk_i, .rst_ni, .rx_valid_i, .rx_data_i, .rx_sof_i, .rx_sel_i, .rx_link_i,
  .rx_crc_i, .permit_o, .fc_sel_o, .fc_sof_o, .fc_req_i
);

// File: tb/tb_fc_flow_cal.sv
module tb_fc_flow_cal;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_len_we = 0, cfg_cal = 0, cfg_sel = 0;
  logic [4:0] cfg_slot = '0;
  logic [2:0] cfg_ch = '0;
  logic [5:0] cfg_len = '0;
  logic [7:0] fill = '0;
  logic link = 1'b1, fc_req = 1'b0;
  logic [15:0] fc_data;
  logic fc_sof, fc_sel, fc_link;
  logic [3:0] fc_crc;
  logic rx_valid = 0, rx_sof = 0, rx_sel = 0, rx_link = 0;
  logic [15:0] rx_data = '0;
  logic [3:0] rx_crc = '0;
  logic [7:0] permit;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fc_flow_cal dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_len_we_i(cfg_len_we), .cfg_cal_i(cfg_cal),
    .cfg_slot_i(cfg_slot), .cfg_ch_i(cfg_ch), .cfg_len_i(cfg_len), .cfg_sel_i(cfg_sel),
    .fill_ok_i(fill), .link_ok_i(link), .fc_req_i(fc_req),
    .fc_data_o(fc_data), .fc_sof_o(fc_sof), .fc_sel_o(fc_sel), .fc_link_o(fc_link),
    .fc_crc_o(fc_crc),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sof_i(rx_sof), .rx_sel_i(rx_sel),
    .rx_link_i(rx_link), .rx_crc_i(rx_crc), .permit_o(permit)
  );

  // {fill, link}
  localparam logic [8:0] VEC [6] = '{
    {8'h00, 1'b1}, {8'hFF, 1'b1}, {8'h3C, 1'b1},
    {8'hFF, 1'b0}, {8'h81, 1'b1}, {8'hA5, 1'b1}
  };

  function automatic logic [3:0] ref_crc(input logic [18:0] m);
    logic [3:0] c;
    c = 4'hF;
    for (int i = 18; i >= 0; i--) begin
      logic t;
      t = c[3] ^ m[i];
      c = {c[2], c[1], c[0] ^ t, t};
    end
    return c;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic sof, input logic sel, input logic lk,
                      input logic [15:0] d, input logic bad);
    @(negedge clk);
    rx_valid = 1; rx_sof = sof; rx_sel = sel; rx_link = lk; rx_data = d;
    rx_crc = ref_crc({sof, sel, lk, d}) ^ {3'b0, bad};
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic wr_map(input logic cal, input int slot, input int ch);
    @(negedge clk);
    cfg_we = 1; cfg_cal = cal; cfg_slot = 5'(slot); cfg_ch = 3'(ch);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    fc_req = 1;
    @(negedge clk);
    fc_req = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] exp_p, held;
    logic [15:0] d0, d1, exp_d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 permits after reset", 32'(permit), 0);
    chk("R10 gen sof after reset", 32'(fc_sof), 1);
    chk("R10 gen sel after reset", 32'(fc_sel), 0);

    // vector table: default calendar 0, identity map, length 8
    foreach (VEC[i]) begin
      @(negedge clk);
      fill = VEC[i][8:1]; link = VEC[i][0];
      #1;
      chk("R1 status chunk", 32'(fc_data), 32'({8'h00, VEC[i][8:1]}));
      chk("R2 link bit", 32'(fc_link), 32'(VEC[i][0]));
      chk("R2 sof on single chunk", 32'(fc_sof), 1);
      chk("R3 crc", 32'(fc_crc), 32'(ref_crc({fc_sof, fc_sel, fc_link, fc_data})));
      rx_valid = 1; rx_sof = fc_sof; rx_sel = fc_sel; rx_link = fc_link;
      rx_data = fc_data; rx_crc = fc_crc; fc_req = 1;
      @(negedge clk);
      rx_valid = 0; fc_req = 0;
      chk("R4 R6 permit after pass", 32'(permit), 32'(VEC[i][0] ? VEC[i][8:1] : 8'h00));
    end
    held = permit;

    send(1, 0, 1, 16'h00FF, 1);
    chk("R5 bad crc holds permits", 32'(permit), 32'(held));
    send(0, 0, 1, 16'h00FF, 0);
    chk("R8 idle non-start chunk ignored", 32'(permit), 32'(held));

    // R9: calendar 1, length 20, slot s -> channel 7 - s%8
    for (int s = 0; s < 20; s++) wr_map(1, s, 7 - (s % 8));
    @(negedge clk);
    cfg_len_we = 1; cfg_cal = 1; cfg_len = 6'd20;
    @(negedge clk);
    cfg_len_we = 0;

    d0 = 16'h00F0; d1 = 16'h0003;
    exp_p = '0;
    for (int s = 0; s < 20; s++) exp_p[7 - (s % 8)] = (s < 16) ? d0[s] : d1[s - 16];
    send(1, 1, 1, d0, 0);
    chk("R4 no update mid-pass", 32'(permit), 32'(held));
    send(0, 1, 1, d1, 0);
    chk("R9 R11 two-chunk pass on calendar 1", 32'(permit), 32'(exp_p));
    held = permit;

    send(1, 1, 1, 16'hFFFF, 0);
    send(0, 0, 1, 16'h000F, 0);
    chk("R8 select change mid-pass aborts", 32'(permit), 32'(held));
    send(0, 1, 1, 16'h000F, 0);
    chk("R8 stray chunk after abort ignored", 32'(permit), 32'(held));

    send(1, 1, 1, 16'hFFFF, 0);
    send(0, 1, 0, 16'h000F, 0);
    chk("R6 link xoff clears all permits", 32'(permit), 0);

    // R7: generator switch-over at boundary only
    @(negedge clk);
    fill = 8'h5A; link = 1; cfg_sel = 1;
    #1;
    chk("R7 select not applied mid-stream", 32'(fc_sel), 0);
    pulse_req();
    chk("R7 select applied at wrap", 32'(fc_sel), 1);
    chk("R2 sof at calendar 1 start", 32'(fc_sof), 1);
    exp_d = '0;
    for (int j = 0; j < 16; j++) exp_d[j] = fill[7 - (j % 8)];
    chk("R1 calendar 1 chunk 0", 32'(fc_data), 32'(exp_d));
    pulse_req();
    @(negedge clk);
    cfg_sel = 0;
    #1;
    chk("R2 chunk 1 no sof", 32'(fc_sof), 0);
    chk("R7 select held in pass", 32'(fc_sel), 1);
    exp_d = '0;
    for (int j = 0; j < 4; j++) exp_d[j] = fill[7 - ((16 + j) % 8)];
    chk("R1 chunk 1 with zero padding", 32'(fc_data), 32'(exp_d));
    chk("R3 crc chunk 1", 32'(fc_crc), 32'(ref_crc({fc_sof, fc_sel, fc_link, fc_data})));
    pulse_req();
    chk("R7 back to calendar 0 at wrap", 32'(fc_sel), 0);
    chk("R2 wrap to chunk 0", 32'(fc_sof), 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule